// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block sits between a simple synchronous host bus and the register port of an ATA disk controller core. It decodes a 4 KB window into register selects. Registers sit 16 bytes apart. Byte-wide accesses reach the seven task-file registers and the control/alternate-status register. Halfword and word accesses reach only the data port. Data crossing the data port has its byte lanes reversed, because the host and the device use opposite byte orders.

Device-side requests are combinational in the cycle the host strobe is high. Read data is registered and appears on the cycle after the read strobe. It is then held until the next read. Accesses that decode to nothing never reach the device. For such a read, the bridge returns all ones for the access width.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits [3:0] and all bits above bit 11 have no effect on decoding.
- R2: A byte access (size code 00) to index 1..7 selects device register 1..7 and raises the matching strobe for that cycle. A byte write places wdata_i[7:0] on dev_wdata_o[7:0] with zeros above. A byte read returns dev_rdata_i[7:0] in rdata_o[7:0] with zeros above.
- R3: A byte access to index 8 or index 22 selects device register code 8. Device register code 8 is device control for writes and alternate status for reads.
- R4: A byte access to any other index, including index 0, raises no device strobe. A byte read of such an index returns 0x000000FF.
- R5: A halfword (size code 01) or word (size code 10) access to index 0 selects device register code 0, the data port. dev_wide_o is 1 for a word access and 0 for a halfword access.
- R6: A halfword or word access to any index other than 0 raises no device strobe. A read returns 0x0000FFFF for a halfword and 0xFFFFFFFF for a word. Size code 11 is never mapped, and its reads return 0xFFFFFFFF.
- R7: Data-port traffic is byte-reversed within the access width in both directions. A halfword swaps bytes 0 and 1 and leaves the upper 16 bits zero. A word maps byte k to byte 3-k.
- R8: rdata_o is zero after reset. It takes its new value at the clock edge that samples rd_i high, and it holds that value while rd_i stays low.
- R9: dev_wr_o and dev_rd_o are high only during cycles in which wr_i or rd_i respectively is high. A write never raises dev_rd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Host byte address |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| wdata_i | input | 32 | Host write data, right-aligned |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| rdata_o | output | 32 | Registered read data |
| dev_reg_o | output | 4 | Device register select: 0 data, 1..7 task file, 8 control/alt status |
| dev_wide_o | output | 1 | Data-port access is a single 32-bit transfer |
| dev_wr_o | output | 1 | Device write strobe |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wdata_o | output | 32 | Lane-adjusted write data to the device |
| dev_rdata_i | input | 32 | Device read data for the selected register |

## Verification
The bench sweeps all 256 indices with every size code for both reads and writes. It mixes the ignored address bits on every access, so a decoder that uses the wrong address slice selects the wrong register. The two control aliases and the boundary indices 0, 7, 8, 9 and 22 are covered by the sweep. A design that aliased only one of index 8 and index 22 would return all ones at the other. A design that let byte accesses reach index 0 would strobe the data port.

The halfword and word checks compare every lane of the data port. They catch a missing or half-done swap, and they catch stray upper bits on halfword traffic. A wrong all-ones width on a miss would show as a wrong rdata_o value. Checks of rdata_o on the idle cycle after each read catch read data that is not held.

// File: rtl/ide_mmio_pkg.sv
package ide_mmio_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int REG_W = 4;
  localparam logic [REG_W-1:0] REG_DATA = 4'd0;
  localparam logic [REG_W-1:0] REG_CTRL = 4'd8;
endpackage

// File: rtl/ide_mmio_decode.sv
module ide_mmio_decode
  import ide_mmio_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int TF_FIRST = 1,
  parameter int TF_LAST  = 7,
  parameter int CTRL_A   = 8,
  parameter int CTRL_B   = 22
) (
  input  logic [IDX_W-1:0] idx_i,
  input  acc_size_e        size_i,
  output logic             hit_o,
  output logic [REG_W-1:0] reg_o,
  output logic             wide_o
);
  logic is_tf, is_ctrl, is_data;

  assign is_tf   = (idx_i >= IDX_W'(TF_FIRST)) && (idx_i <= IDX_W'(TF_LAST));
  assign is_ctrl = (idx_i == IDX_W'(CTRL_A)) || (idx_i == IDX_W'(CTRL_B));
  assign is_data = (idx_i == '0);

  always_comb begin
    hit_o  = 1'b0;
    reg_o  = REG_DATA;
    wide_o = 1'b0;
    unique case (size_i)
      SZ_BYTE: begin
        if (is_tf) begin
          hit_o = 1'b1;
          reg_o = idx_i[REG_W-1:0];
        end else if (is_ctrl) begin
          hit_o = 1'b1;
          reg_o = REG_CTRL;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (is_data) begin
          hit_o  = 1'b1;
          wide_o = (size_i == SZ_WORD);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ide_mmio_lane_swap.sv
module ide_mmio_lane_swap
  import ide_mmio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int NB = DATA_W / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0] half_b, byte_b, lane_q;

    if (i < 2) begin : g_half
      assign half_b = d_i[8*(1-i) +: 8];
    end else begin : g_half_zero
      assign half_b = '0;
    end

    if (i == 0) begin : g_byte
      assign byte_b = d_i[7:0];
    end else begin : g_byte_zero
      assign byte_b = '0;
    end

    always_comb begin
      unique case (size_i)
        SZ_HALF: lane_q = half_b;
        SZ_WORD: lane_q = d_i[8*(NB-1-i) +: 8];
        default: lane_q = byte_b;
      endcase
    end

    assign q_o[8*i +: 8] = lane_q;
  end
endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
  import ide_mmio_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_W    = 12,
  parameter int STRIDE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [REG_W-1:0]  dev_reg_o,
  output logic              dev_wide_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i
);
  localparam int IDX_W = WIN_W - STRIDE_W;

  acc_size_e         size_e;
  logic [IDX_W-1:0]  host_idx;
  logic              hit;
  logic [DATA_W-1:0] rd_swapped, miss_val, rdata_q;
  logic              unused_addr_bits;

  assign size_e   = acc_size_e'(size_i);
  assign host_idx = addr_i[WIN_W-1:STRIDE_W];
  assign unused_addr_bits = ^{addr_i[ADDR_W-1:WIN_W], addr_i[STRIDE_W-1:0]};

  ide_mmio_decode #(.IDX_W(IDX_W)) u_decode (
    .idx_i  (host_idx),
    .size_i (size_e),
    .hit_o  (hit),
    .reg_o  (dev_reg_o),
    .wide_o (dev_wide_o)
  );

  ide_mmio_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .size_i (size_e),
    .d_i    (wdata_i),
    .q_o    (dev_wdata_o)
  );

  ide_mmio_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .size_i (size_e),
    .d_i    (dev_rdata_i),
    .q_o    (rd_swapped)
  );

  assign dev_wr_o = wr_i & hit;
  assign dev_rd_o = rd_i & hit;

  // all ones for the access width on a miss
  always_comb begin
    unique case (size_e)
      SZ_BYTE: miss_val = DATA_W'(8'hFF);
      SZ_HALF: miss_val = DATA_W'(16'hFFFF);
      default: miss_val = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= hit ? rd_swapped : miss_val;
  end

  assign rdata_o = rdata_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_byte_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !dev_rd_o && size_e == SZ_BYTE) |=> (rdata_o == DATA_W'(8'hFF)));

  p_word_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !dev_rd_o && size_e == SZ_WORD) |=> (rdata_o == '1));

  p_wide_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_rd_o || dev_wr_o) && size_e != SZ_BYTE) |-> (dev_reg_o == REG_DATA));

  p_wide_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_wide_o |-> (size_e == SZ_WORD));

  p_taskfile_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_rd_o || dev_wr_o) && size_e == SZ_BYTE && host_idx >= 1 && host_idx <= 7)
      |-> (dev_reg_o == host_idx[REG_W-1:0]));

  p_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_rd_o || dev_wr_o) && size_e == SZ_BYTE && (host_idx == 8 || host_idx == 22))
      |-> (dev_reg_o == REG_CTRL));

  p_half_swap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o && size_e == SZ_HALF)
      |-> (dev_wdata_o[7:0] == wdata_i[15:8] && dev_wdata_o[15:8] == wdata_i[7:0]));

  p_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rd_o && dev_wr_o) || (rd_i && wr_i));
endmodule

// File: tb/ide_mmio_bridge_test.sv
module ide_mmio_bridge_test;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  size = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata, dev_wdata, dev_rdata;
  logic [3:0]  dev_reg;
  logic        dev_wide, dev_wr, dev_rd;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // device model: register-dependent pattern
  assign dev_rdata = 32'hC1D2E3F4 + {28'h0, dev_reg};

  ide_mmio_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rd_i(rd), .wr_i(wr), .rdata_o(rdata),
    .dev_reg_o(dev_reg), .dev_wide_o(dev_wide), .dev_wr_o(dev_wr),
    .dev_rd_o(dev_rd), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(int idx, int sz);
    if (sz == 0) return (idx >= 1 && idx <= 7) || idx == 8 || idx == 22;
    if (sz == 1 || sz == 2) return idx == 0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_reg(int idx, int sz);
    if (sz == 0 && idx >= 1 && idx <= 7) return 4'(idx);
    if (sz == 0) return 4'd8;
    return 4'd0;
  endfunction

  function automatic logic [31:0] rev(logic [31:0] d, int sz);
    logic [31:0] q = '0;
    if (sz == 0) q = {24'h0, d[7:0]};
    else if (sz == 1) q = {16'h0, d[7:0], d[15:8]};
    else for (int k = 0; k < 4; k++) q[8*k +: 8] = d[8*(3-k) +: 8];
    return q;
  endfunction

  function automatic logic [31:0] miss(int sz);
    if (sz == 0) return 32'h0000_00FF;
    if (sz == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mk_addr(int idx, int sz);
    logic [19:0] hi = 20'hA5000 ^ 20'(idx * 331 + sz * 7);
    return {hi, 8'(idx), 4'(idx * 3 + sz)};
  endfunction

  task automatic do_read(int idx, int sz);
    logic [31:0] exp;
    bit h = exp_hit(idx, sz);
    @(negedge clk);
    addr = mk_addr(idx, sz); size = 2'(sz); rd = 1'b1;
    #1;
    chk($sformatf("R9/R4/R6 dev_rd idx%0d sz%0d", idx, sz), {31'h0, dev_rd}, {31'h0, h});
    chk($sformatf("R9 no wr on read idx%0d", idx), {31'h0, dev_wr}, 32'h0);
    if (h) begin
      chk($sformatf("R1/R2/R3/R5 reg idx%0d sz%0d", idx, sz), {28'h0, dev_reg}, {28'h0, exp_reg(idx, sz)});
      chk($sformatf("R5 wide idx%0d sz%0d", idx, sz), {31'h0, dev_wide}, {31'h0, sz == 2});
    end
    exp = h ? rev(32'hC1D2E3F4 + {28'h0, exp_reg(idx, sz)}, sz) : miss(sz);
    @(negedge clk);
    rd = 1'b0; addr = 32'h0000_0FF0; size = 2'd2;
    #1;
    chk($sformatf("R8/R7 rdata idx%0d sz%0d", idx, sz), rdata, exp);
    chk("R9 dev_rd drops", {31'h0, dev_rd}, 32'h0);
    @(negedge clk);
    chk($sformatf("R8 hold idx%0d sz%0d", idx, sz), rdata, exp);
  endtask

  task automatic do_write(int idx, int sz);
    bit h = exp_hit(idx, sz);
    logic [31:0] wd = 32'h8C4B2A19 ^ (32'(idx) << 8) ^ 32'(sz);
    @(negedge clk);
    addr = mk_addr(idx, sz); size = 2'(sz); wdata = wd; wr = 1'b1;
    #1;
    chk($sformatf("R9/R4/R6 dev_wr idx%0d sz%0d", idx, sz), {31'h0, dev_wr}, {31'h0, h});
    chk($sformatf("R9 no rd on write idx%0d", idx), {31'h0, dev_rd}, 32'h0);
    if (h) begin
      chk($sformatf("R1/R2/R3/R5 wreg idx%0d sz%0d", idx, sz), {28'h0, dev_reg}, {28'h0, exp_reg(idx, sz)});
      chk($sformatf("R7/R2 wdata idx%0d sz%0d", idx, sz), dev_wdata, rev(wd, sz));
    end
    @(negedge clk);
    wr = 1'b0;
    #1;
    chk("R9 dev_wr one cycle", {31'h0, dev_wr}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset rdata", rdata, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 rdata after reset", rdata, 32'h0);
    chk("R9 idle dev_wr", {31'h0, dev_wr}, 32'h0);
    for (int idx = 0; idx < 256; idx++) begin
      for (int sz = 0; sz < 4; sz++) begin
        do_read(idx, sz);
        do_write(idx, sz);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule